// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Sequencer

This block moves a chip from one operating point to another. An operating point is one of eight fixed, pre-validated pairs of a supply-voltage code and a clock-frequency code. Index 0 is the fastest pair and index 7 is the slowest. A power-management policy outside the block sends a target index. The block then drives two separate subsystems, each over its own request/acknowledge handshake: a voltage regulator and a clock generator.

The order of the two steps depends on the direction of the move. When speeding up, the voltage is raised and given time to settle before the clock is raised. When slowing down, the clock is lowered first and the voltage is reduced after it. The clock therefore never runs faster than the present supply can carry. After each acknowledge the block holds off for a fixed settle time.

A thermal ceiling input names the fastest index that is currently allowed. Any faster request is clamped to that ceiling. If the ceiling moves below the present point while the block is idle, the block steps down on its own. A request that arrives during a transition is held, and only the newest one is kept. A handshake that is not acknowledged in time stops the sequencer at its last safe point and raises a sticky error.

Top module: `pstate_seq`

## Requirements
- R1: Entry i of the table has voltage code 200 − 12·i and frequency code 240 − 25·i, as 8-bit values. A code issued to either subsystem is always an entry of this table, and it is the entry of the target state.
- R2: For a move to a lower index (faster), the voltage step is requested and acknowledged before the frequency step is requested.
- R3: For a move to a higher index (slower), the frequency step is requested and acknowledged before the voltage step is requested.
- R4: The state reached for a request `req_idx` is the larger of `req_idx` and `therm_cap`.
- R5: While idle with no held request, a current state below `therm_cap` starts a transition to `therm_cap` on its own.
- R6: After each acknowledge, at least `SETTLE_CYC` clock cycles pass before the next request or the completion.
- R7: A request output stays high with a stable code until its acknowledge arrives. At most one of the two request outputs is high at a time.
- R8: Requests that arrive during a transition are held. When that transition ends, only the most recent one is carried out.
- R9: A request held for `TIMEOUT_CYC` cycles without an acknowledge sets `err`. `err` stays set until reset. `cur_state` keeps its last completed value, and no further subsystem request is issued.
- R10: `busy` is high while a transition is in progress. `done` is a one-cycle pulse for each completed request, and `cur_state` changes only with it. A request that resolves to the current state issues no subsystem request and still pulses `done`.
- R11: After reset, `cur_state` is 7, `busy`, `done`, `err` and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle strobe carrying a new target |
| req_idx | input | 3 | Requested state index, 0 = fastest |
| therm_cap | input | 3 | Fastest index currently allowed |
| vreg_req | output | 1 | Voltage-regulator request |
| vreg_code | output | 8 | Voltage code for the regulator |
| vreg_ack | input | 1 | Regulator acknowledge |
| clkgen_req | output | 1 | Clock-generator request |
| clkgen_code | output | 8 | Frequency code for the clock generator |
| clkgen_ack | input | 1 | Clock-generator acknowledge |
| cur_state | output | 3 | Last completed state index |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky handshake-timeout flag |

## Verification
The assertions take for granted that each acknowledge is a single-cycle pulse. They also assume an acknowledge comes only while the matching request is high, and that `req_valid` is a single-cycle strobe. The bench's regulator and clock-generator models answer three cycles after they see a request and drop the acknowledge on the next cycle. For the timeout case they never answer. The stimulus changes `therm_cap` only while the block is idle and waits for the block to go quiet between cases. The one exception is the held-request case, which deliberately sends requests while the block is busy.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    localparam int PS_COUNT = 8;
    localparam int PS_IDX_W = $clog2(PS_COUNT);
    localparam int VCODE_W  = 8;
    localparam int FCODE_W  = 8;
    localparam int V_TOP    = 200;
    localparam int V_STEP   = 12;
    localparam int F_TOP    = 240;
    localparam int F_STEP   = 25;

    typedef logic [PS_IDX_W-1:0] ps_idx_t;
    typedef logic [VCODE_W-1:0]  vcode_t;
    typedef logic [FCODE_W-1:0]  fcode_t;

    typedef struct packed {
        vcode_t vcode;
        fcode_t fcode;
    } vf_pair_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_A_REQ,
        SQ_A_SETTLE,
        SQ_B_REQ,
        SQ_B_SETTLE,
        SQ_FAULT
    } sq_state_t;

    localparam ps_idx_t PS_SLOWEST = ps_idx_t'(PS_COUNT - 1);

    function automatic vf_pair_t pair_of(ps_idx_t idx);
        vf_pair_t p;
        int v;
        int f;
        v = V_TOP - V_STEP * int'(idx);
        f = F_TOP - F_STEP * int'(idx);
        p.vcode = v[VCODE_W-1:0];
        p.fcode = f[FCODE_W-1:0];
        return p;
    endfunction

    function automatic ps_idx_t clamp_idx(ps_idx_t want, ps_idx_t ceiling);
        return (want < ceiling) ? ceiling : want;
    endfunction

    function automatic logic legal_vcode(vcode_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < PS_COUNT; i++)
            if (pair_of(ps_idx_t'(i)).vcode == c) hit = 1'b1;
        return hit;
    endfunction

    function automatic logic legal_fcode(fcode_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < PS_COUNT; i++)
            if (pair_of(ps_idx_t'(i)).fcode == c) hit = 1'b1;
        return hit;
    endfunction

endpackage

// File: rtl/pstate_hold.sv
module pstate_hold
    import pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  ps_idx_t req_idx,
    input  logic    take,
    output logic    pend_vld,
    output ps_idx_t pend_idx
);
    // newest strobe overwrites any held target (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend_idx <= PS_SLOWEST;
        end else if (req_valid) begin
            pend_vld <= 1'b1;
            pend_idx <= req_idx;
        end else if (take) begin
            pend_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/pstate_timer.sv
module pstate_timer #(
    parameter int SETTLE_CYC  = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic settle_hit,
    output logic timeout_hit
);
    localparam int LIMIT = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] SAT      = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)     cnt <= '0;
        else if (cnt != SAT) cnt <= cnt + 1'b1;
    end

    assign settle_hit  = (cnt == SET_LAST);
    assign timeout_hit = (cnt == TMO_LAST);
endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
    import pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pend_vld,
    input  ps_idx_t pend_idx,
    input  ps_idx_t therm_cap,
    input  logic    vreg_ack,
    input  logic    clkgen_ack,
    input  logic    settle_hit,
    input  logic    timeout_hit,
    output logic    take,
    output logic    timer_clr,
    output logic    vreg_req,
    output vcode_t  vreg_code,
    output logic    clkgen_req,
    output fcode_t  clkgen_code,
    output ps_idx_t cur_state,
    output logic    busy,
    output logic    done,
    output logic    err
);
    sq_state_t st, nxt;
    ps_idx_t   cur_q, tgt_q, tgt_n;
    logic      up_q, up_n;
    logic      same_hit, finish, v_step, step_ack;
    vf_pair_t  tgt_pair;

    // speeding up: voltage leads (R2); slowing down: clock leads (R3)
    assign v_step   = (st == SQ_A_REQ || st == SQ_A_SETTLE) ? up_q : !up_q;
    assign step_ack = v_step ? vreg_ack : clkgen_ack;
    assign finish   = (st == SQ_B_SETTLE) && settle_hit;

    always_comb begin
        nxt      = st;
        take     = 1'b0;
        same_hit = 1'b0;
        tgt_n    = tgt_q;
        up_n     = up_q;
        unique case (st)
            SQ_IDLE: begin
                if (pend_vld) begin
                    take  = 1'b1;
                    tgt_n = clamp_idx(pend_idx, therm_cap);
                    if (tgt_n == cur_q) begin
                        same_hit = 1'b1;
                    end else begin
                        nxt  = SQ_A_REQ;
                        up_n = (tgt_n < cur_q);
                    end
                end else if (cur_q < therm_cap) begin
                    tgt_n = therm_cap;
                    up_n  = 1'b0;
                    nxt   = SQ_A_REQ;
                end
            end
            SQ_A_REQ: begin
                if (step_ack)         nxt = SQ_A_SETTLE;
                else if (timeout_hit) nxt = SQ_FAULT;
            end
            SQ_A_SETTLE: if (settle_hit) nxt = SQ_B_REQ;
            SQ_B_REQ: begin
                if (step_ack)         nxt = SQ_B_SETTLE;
                else if (timeout_hit) nxt = SQ_FAULT;
            end
            SQ_B_SETTLE: if (settle_hit) nxt = SQ_IDLE;
            SQ_FAULT:    nxt = SQ_FAULT;
            default:     nxt = SQ_IDLE;
        endcase
    end

    assign timer_clr = (nxt != st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            cur_q <= PS_SLOWEST;
            tgt_q <= PS_SLOWEST;
            up_q  <= 1'b0;
            done  <= 1'b0;
        end else begin
            st    <= nxt;
            tgt_q <= tgt_n;
            up_q  <= up_n;
            done  <= same_hit || finish;
            if (finish) cur_q <= tgt_q;
        end
    end

    assign tgt_pair    = pair_of(tgt_q);
    assign vreg_code   = tgt_pair.vcode;
    assign clkgen_code = tgt_pair.fcode;
    assign vreg_req    = ((st == SQ_A_REQ) && up_q) || ((st == SQ_B_REQ) && !up_q);
    assign clkgen_req  = ((st == SQ_A_REQ) && !up_q) || ((st == SQ_B_REQ) && up_q);
    assign cur_state   = cur_q;
    assign busy        = (st != SQ_IDLE) && (st != SQ_FAULT);
    assign err         = (st == SQ_FAULT);
endmodule

// File: rtl/pstate_seq.sv
module pstate_seq
    import pstate_pkg::*;
#(
    parameter int SETTLE_CYC  = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [PS_IDX_W-1:0] req_idx,
    input  logic [PS_IDX_W-1:0] therm_cap,
    output logic                vreg_req,
    output logic [VCODE_W-1:0]  vreg_code,
    input  logic                vreg_ack,
    output logic                clkgen_req,
    output logic [FCODE_W-1:0]  clkgen_code,
    input  logic                clkgen_ack,
    output logic [PS_IDX_W-1:0] cur_state,
    output logic                busy,
    output logic                done,
    output logic                err
);
    logic    take, pend_vld, timer_clr, settle_hit, timeout_hit;
    ps_idx_t pend_idx;

    pstate_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .take      (take),
        .pend_vld  (pend_vld),
        .pend_idx  (pend_idx)
    );

    pstate_timer #(
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clr         (timer_clr),
        .settle_hit  (settle_hit),
        .timeout_hit (timeout_hit)
    );

    pstate_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pend_vld    (pend_vld),
        .pend_idx    (pend_idx),
        .therm_cap   (therm_cap),
        .vreg_ack    (vreg_ack),
        .clkgen_ack  (clkgen_ack),
        .settle_hit  (settle_hit),
        .timeout_hit (timeout_hit),
        .take        (take),
        .timer_clr   (timer_clr),
        .vreg_req    (vreg_req),
        .vreg_code   (vreg_code),
        .clkgen_req  (clkgen_req),
        .clkgen_code (clkgen_code),
        .cur_state   (cur_state),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );
endmodule

// File: rtl/pstate_seq_chk.sv
module pstate_seq_chk
    import pstate_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                vreg_req,
    input logic [VCODE_W-1:0]  vreg_code,
    input logic                vreg_ack,
    input logic                clkgen_req,
    input logic [FCODE_W-1:0]  clkgen_code,
    input logic                clkgen_ack,
    input logic [PS_IDX_W-1:0] cur_state,
    input logic                busy,
    input logic                done,
    input logic                err
);
    p_one_channel_r7: assert property (@(posedge clk) disable iff (rst)
        !(vreg_req && clkgen_req));

    p_vreg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (vreg_req && !vreg_ack) |=> err || (vreg_req && $stable(vreg_code)));

    p_clkgen_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (clkgen_req && !clkgen_ack) |=> err || (clkgen_req && $stable(clkgen_code)));

    p_vcode_legal_r1: assert property (@(posedge clk) disable iff (rst)
        vreg_req |-> legal_vcode(vreg_code));

    p_fcode_legal_r1: assert property (@(posedge clk) disable iff (rst)
        clkgen_req |-> legal_fcode(clkgen_code));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_state_moves_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_state) |-> done);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err && $stable(cur_state));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !vreg_req && !clkgen_req && !busy);
endmodule

bind pstate_seq pstate_seq_chk chk_i (.*);

// File: tb/pstate_seq_tb.sv
`timescale 1ns/1ps
module pstate_seq_tb_top;
    localparam int SETTLE = 16;
    localparam int TMO    = 64;
    localparam int RDLY   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_idx = '0;
    logic [2:0] therm_cap = '0;
    logic       vreg_req, clkgen_req, vreg_ack = 1'b0, clkgen_ack = 1'b0;
    logic [7:0] vreg_code, clkgen_code;
    logic [2:0] cur_state;
    logic       busy, done, err;

    always #2.5 clk = ~clk;

    pstate_seq #(.SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) dut_i (.*);

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    function automatic int tb_v(int i); return 200 - 12 * i; endfunction
    function automatic int tb_f(int i); return 240 - 25 * i; endfunction
    function automatic int f_to_idx(int code);
        for (int i = 0; i < 8; i++) if (tb_f(i) == code) return i;
        return 99;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // regulator / clock-generator models and event monitor
    bit  resp_en = 1'b1;
    int  vcnt = 0, fcnt = 0, cyc = 0, last_ack = -1000;
    int  app_v = 200 - 12 * 7, app_f = 240 - 25 * 7;
    int  ev_n = 0, done_cnt = 0;
    bit  ev_v [4];
    bit  vreq_d = 1'b0, freq_d = 1'b0;

    always @(negedge clk) begin
        cyc++;
        vreg_ack   <= 1'b0;
        clkgen_ack <= 1'b0;
        if (!rst) begin
            if (done) done_cnt++;
            if (vreg_req && clkgen_req) check(1'b0, "R7 both requests high", 1, 0);
            if ((vreg_req && !vreg_ack && !vreq_d) || (clkgen_req && !clkgen_ack && !freq_d))
                check(cyc - last_ack >= SETTLE, "R6 settle gap", cyc - last_ack, SETTLE);
        end
        if (rst || !vreg_req) vcnt <= 0;
        else if (resp_en && !vreg_ack) begin
            if (vcnt == RDLY) begin
                vreg_ack <= 1'b1;
                check(int'(vreg_code) >= tb_v(f_to_idx(app_f)), "R3 voltage below clock need",
                      int'(vreg_code), tb_v(f_to_idx(app_f)));
                app_v = int'(vreg_code);
                if (ev_n < 4) ev_v[ev_n] = 1'b1;
                ev_n++;
                last_ack = cyc;
            end
            vcnt <= vcnt + 1;
        end
        if (rst || !clkgen_req) fcnt <= 0;
        else if (resp_en && !clkgen_ack) begin
            if (fcnt == RDLY) begin
                clkgen_ack <= 1'b1;
                check(app_v >= tb_v(f_to_idx(int'(clkgen_code))), "R2 clock above voltage",
                      app_v, tb_v(f_to_idx(int'(clkgen_code))));
                app_f = int'(clkgen_code);
                if (ev_n < 4) ev_v[ev_n] = 1'b0;
                ev_n++;
                last_ack = cyc;
            end
            fcnt <= fcnt + 1;
        end
        vreq_d <= vreg_req;
        freq_d <= clkgen_req;
    end

    task automatic pulse_req(int idx);
        @(negedge clk);
        req_valid = 1'b1;
        req_idx   = 3'(idx);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int n = 0; n < 3000 && q < 3; n++) begin
            @(negedge clk);
            q = busy ? 0 : q + 1;
        end
        if (q < 3) check(1'b0, "R10 busy never dropped", 1, 0);
    endtask

    // vector: {req_idx, therm_cap}
    localparam int NV = 11;
    localparam logic [5:0] VEC [NV] = '{
        {3'd0, 3'd0}, {3'd3, 3'd0}, {3'd3, 3'd0}, {3'd1, 3'd0}, {3'd6, 3'd0},
        {3'd0, 3'd4}, {3'd2, 3'd2}, {3'd7, 3'd0}, {3'd5, 3'd6}, {3'd0, 3'd6},
        {3'd0, 3'd1}
    };

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(cur_state == 3'd7, "R11 cur_state after reset", cur_state, 7);
        check(!busy && !done && !err, "R11 flags after reset", {busy, done, err}, 0);
        check(!vreg_req && !clkgen_req, "R11 requests after reset", {vreg_req, clkgen_req}, 0);

        for (int k = 0; k < NV; k++) begin
            int r, c, prev, exp, d0;
            r = int'(VEC[k][5:3]);
            c = int'(VEC[k][2:0]);
            prev = int'(cur_state);
            exp = (r < c) ? c : r;
            @(negedge clk);
            therm_cap = 3'(c);
            wait_quiet();
            ev_n = 0;
            d0 = done_cnt;
            pulse_req(r);
            wait_quiet();
            check(int'(cur_state) == exp, "R4 reached state", cur_state, exp);
            check(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
            check(app_v == tb_v(exp), "R1 voltage code", app_v, tb_v(exp));
            check(app_f == tb_f(exp), "R1 frequency code", app_f, tb_f(exp));
            if (exp == prev)
                check(ev_n == 0, "R10 same state issues nothing", ev_n, 0);
            else begin
                check(ev_n == 2, "R2 R3 two steps", ev_n, 2);
                if (exp < prev) check(ev_v[0] == 1'b1, "R2 voltage first when faster", ev_v[0], 1);
                else            check(ev_v[0] == 1'b0, "R3 clock first when slower", ev_v[0], 0);
            end
        end

        // R8 latest held request wins
        begin
            int d0;
            therm_cap = 3'd0;
            pulse_req(0);
            wait_quiet();
            d0 = done_cnt;
            pulse_req(7);
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R10 busy during transition", busy, 1);
            pulse_req(5);
            pulse_req(2);
            wait_quiet();
            check(cur_state == 3'd2, "R8 newest held request", cur_state, 2);
            check(done_cnt - d0 == 2, "R8 older held request dropped", done_cnt - d0, 2);
        end

        // R5 ceiling forces a step down while idle
        ev_n = 0;
        @(negedge clk);
        therm_cap = 3'd5;
        wait_quiet();
        check(cur_state == 3'd5, "R5 forced to ceiling", cur_state, 5);
        check(ev_n == 2 && ev_v[0] == 1'b0, "R5 forced move clock first", ev_v[0], 0);
        therm_cap = 3'd0;
        wait_quiet();
        check(cur_state == 3'd5, "R5 lower ceiling no move", cur_state, 5);

        // R9 timeout
        resp_en = 1'b0;
        ev_n = 0;
        pulse_req(0);
        repeat (TMO + 20) @(negedge clk);
        check(err == 1'b1, "R9 err after timeout", err, 1);
        check(cur_state == 3'd5, "R9 state kept", cur_state, 5);
        check(!vreg_req && !clkgen_req && !busy, "R9 quiet after fault",
              {vreg_req, clkgen_req, busy}, 0);
        resp_en = 1'b1;
        pulse_req(7);
        repeat (100) @(negedge clk);
        check(cur_state == 3'd5 && ev_n == 0, "R9 requests ignored in fault", cur_state, 5);
        check(err == 1'b1, "R9 err sticky", err, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!err && cur_state == 3'd7, "R11 reset clears fault", {err, cur_state}, 7);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule